// File: doc/BRIEF.md
# Per-Port Timestamp Capture Bank

This block keeps a small bank of packet timestamp slots, a fixed number for each port. A packet event names a port and a slot. On that event the block stores the low 40 bits of a free-running timer input into the slot and marks the slot occupied. Receive events are always taken. Transmit events are taken only when the event also carries a capture request.

Software reads each slot through two 32-bit registers. The low word holds the timer bits 31:0. The high word holds bits 39:32 and the occupied flag. Software frees a slot by writing zero to its registers. A capture aimed at an occupied slot is lost and raises a sticky per-port overflow flag. If a capture and a freeing write hit the same slot in the same cycle, the capture wins.

Top module: `ts_capture_bank`

## Requirements
- R1: After reset every slot is empty, every register reads zero and every overflow flag is zero.
- R2: A receive event (`cap_tx_i` low) to an empty slot stores `timer_i[39:0]` as sampled at the clock edge where `cap_valid_i` is high, and marks the slot occupied.
- R3: An accepted event aimed at an occupied slot leaves the slot unchanged and sets `ovf_o[port]`. The flag stays set until reset, including after the slot is later freed and used again.
- R4: A transmit event (`cap_tx_i` high) is taken only when `cap_txreq_i` is high. Without the request it changes no slot and no overflow flag.
- R5: Register address layout is `{bank, port, slot}`: bit `ADDR_W-1` selects the bank (0 = low word, 1 = high word), the lowest `SLOT_W` bits select the slot, and the bits between select the port. The low word reads stored bits 31:0. The high word reads the occupied flag in bit 31 and stored bits 39:32 in bits 7:0, with bits 30:8 zero.
- R6: Writing zero to the low word clears stored bits 31:0. Writing zero to the high word clears stored bits 39:32 and the occupied flag.
- R7: A write of a nonzero value to either register has no effect.
- R8: When an accepted event and a zero write to the high word hit the same slot in the same cycle, the slot takes the new timestamp and stays occupied, and no overflow is raised, even if the slot was occupied before.
- R9: An event changes only the slot it names; every other slot keeps its contents.
- R10: `reg_rdata_o` shows the register addressed by `reg_addr_i` one clock edge earlier, and reading has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_i | input | TMR_W | Running port timer; the low 40 bits are captured |
| cap_valid_i | input | 1 | Packet event strobe |
| cap_tx_i | input | 1 | Event direction: 1 = transmit, 0 = receive |
| cap_txreq_i | input | 1 | Capture request for transmit events |
| cap_port_i | input | PORT_W | Port named by the event |
| cap_slot_i | input | SLOT_W | Slot named by the event |
| reg_addr_i | input | ADDR_W | Register address {bank, port, slot} |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the address |
| ovf_o | output | NUM_PORTS | Sticky per-port overflow flags |

## Verification
Captures are driven with timer values whose low 40 bits differ in every byte, so the low/high split, the top-byte placement and the occupied bit can each be told apart on readback. Second captures into an occupied slot show whether the old value is kept and which port's flag rises. Transmit events with and without the request separate the two acceptance paths. Zero and nonzero writes to each word, plus a capture that lands in the same cycle as a high-word clear, separate the clear rules from the priority rule. A fast address change without a wait shows the one-cycle read latency.

// File: rtl/ts_bank_pkg.sv
package ts_bank_pkg;
    localparam int TS_W  = 40;           // captured timer width
    localparam int REG_W = 32;           // software register width
    localparam int LO_W  = REG_W;        // bits held in the low word
    localparam int HI_W  = TS_W - LO_W;  // bits held in the high word

    typedef struct packed {
        logic            valid;
        logic [TS_W-1:0] ts;
    } slot_t;

    // Build the software-visible word of a slot for the selected bank.
    function automatic logic [REG_W-1:0] fmt_word(slot_t s, logic hi);
        logic [REG_W-1:0] w;
        w = '0;
        if (hi) begin
            w[REG_W-1]  = s.valid;
            w[HI_W-1:0] = s.ts[TS_W-1:LO_W];
        end else begin
            w = s.ts[LO_W-1:0];
        end
        return w;
    endfunction
endpackage

// File: rtl/ts_reg_decode.sv
module ts_reg_decode
    import ts_bank_pkg::*;
#(
    parameter int TOTAL = 8,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W:0]     addr_i,
    input  logic               wr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [TOTAL-1:0]   clr_lo_o,
    output logic [TOTAL-1:0]   clr_hi_o,
    output logic [IDX_W-1:0]   rd_idx_o,
    output logic               rd_hi_o
);
    logic zero_wr;
    logic hi_bank;

    assign zero_wr  = wr_i && (wdata_i == '0);
    assign hi_bank  = addr_i[IDX_W];
    assign rd_idx_o = addr_i[IDX_W-1:0];
    assign rd_hi_o  = hi_bank;

    for (genvar i = 0; i < TOTAL; i++) begin : g_dec
        logic hit;
        assign hit         = zero_wr && (addr_i[IDX_W-1:0] == IDX_W'(i));
        assign clr_lo_o[i] = hit && !hi_bank;
        assign clr_hi_o[i] = hit &&  hi_bank;
    end
endmodule

// File: rtl/ts_slot.sv
module ts_slot
    import ts_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_i,
    input  logic [TS_W-1:0] ts_i,
    input  logic            clr_lo_i,
    input  logic            clr_hi_i,
    output slot_t           state_o,
    output logic            drop_o
);
    slot_t s_d, s_q;
    logic  take;

    always_comb begin
        s_d  = s_q;
        // a same-cycle high clear frees the slot for this capture
        take = cap_i && (!s_q.valid || clr_hi_i);
        if (take) begin
            s_d.valid = 1'b1;
            s_d.ts    = ts_i;
        end else begin
            if (clr_lo_i) s_d.ts[LO_W-1:0] = '0;
            if (clr_hi_i) begin
                s_d.ts[TS_W-1:LO_W] = '0;
                s_d.valid           = 1'b0;
            end
        end
        drop_o = cap_i && !take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign state_o = s_q;
endmodule

// File: rtl/ts_capture_bank.sv
module ts_capture_bank
    import ts_bank_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int SLOTS     = 4,   // per port, power of two
    parameter int TMR_W     = 64,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int IDX_W    = PORT_W + SLOT_W,
    localparam int ADDR_W   = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TMR_W-1:0]   timer_i,
    input  logic               cap_valid_i,
    input  logic               cap_tx_i,
    input  logic               cap_txreq_i,
    input  logic [PORT_W-1:0]  cap_port_i,
    input  logic [SLOT_W-1:0]  cap_slot_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_wr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]   reg_rdata_o,
    output logic [NUM_PORTS-1:0] ovf_o
);
    localparam int TOTAL = NUM_PORTS * SLOTS;

    typedef struct packed {
        logic [NUM_PORTS-1:0] ovf;
        logic [REG_W-1:0]     rdata;
    } top_t;

    top_t top_d, top_q;

    logic              cap_accept;
    logic [IDX_W-1:0]  cap_idx;
    logic [TOTAL-1:0]  cap_hit;
    logic [TOTAL-1:0]  clr_lo;
    logic [TOTAL-1:0]  clr_hi;
    logic [TOTAL-1:0]  drop;
    logic [NUM_PORTS-1:0] port_drop;
    logic [IDX_W-1:0]  rd_idx;
    logic              rd_hi;
    slot_t             slots [TOTAL];

    // receive events always count, transmit events only on request
    assign cap_accept = cap_valid_i && (!cap_tx_i || cap_txreq_i);
    assign cap_idx    = {cap_port_i, cap_slot_i};

    ts_reg_decode #(.TOTAL(TOTAL), .IDX_W(IDX_W)) u_dec (
        .addr_i   (reg_addr_i),
        .wr_i     (reg_wr_i),
        .wdata_i  (reg_wdata_i),
        .clr_lo_o (clr_lo),
        .clr_hi_o (clr_hi),
        .rd_idx_o (rd_idx),
        .rd_hi_o  (rd_hi)
    );

    for (genvar i = 0; i < TOTAL; i++) begin : g_slot
        assign cap_hit[i] = cap_accept && (cap_idx == IDX_W'(i));
        ts_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_i    (cap_hit[i]),
            .ts_i     (timer_i[TS_W-1:0]),
            .clr_lo_i (clr_lo[i]),
            .clr_hi_i (clr_hi[i]),
            .state_o  (slots[i]),
            .drop_o   (drop[i])
        );
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign port_drop[p] = |drop[p*SLOTS +: SLOTS];
    end

    always_comb begin
        top_d     = top_q;
        top_d.ovf = top_q.ovf | port_drop;
        if (int'(rd_idx) < TOTAL) top_d.rdata = fmt_word(slots[rd_idx], rd_hi);
        else                      top_d.rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign reg_rdata_o = top_q.rdata;
    assign ovf_o       = top_q.ovf;
endmodule

// File: rtl/ts_capture_bank_chk.sv
module ts_capture_bank_chk #(
    parameter int NUM_PORTS = 2,
    parameter int PORT_W    = 1,
    parameter int SLOT_W    = 2,
    parameter int IDX_W     = 3,
    parameter int ADDR_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cap_valid_i,
    input logic                 cap_tx_i,
    input logic                 cap_txreq_i,
    input logic [PORT_W-1:0]    cap_port_i,
    input logic [SLOT_W-1:0]    cap_slot_i,
    input logic [ADDR_W-1:0]    reg_addr_i,
    input logic                 reg_wr_i,
    input logic [31:0]          reg_wdata_i,
    input logic [31:0]          reg_rdata_o,
    input logic [NUM_PORTS-1:0] ovf_o
);
    logic tx_blocked;
    logic cap_and_hiclr;

    assign tx_blocked    = cap_valid_i && cap_tx_i && !cap_txreq_i;
    assign cap_and_hiclr = cap_valid_i && (!cap_tx_i || cap_txreq_i) && reg_wr_i
                        && (reg_wdata_i == '0) && reg_addr_i[ADDR_W-1]
                        && (reg_addr_i[IDX_W-1:0] == {cap_port_i, cap_slot_i});

    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ovf_o == '0 && reg_rdata_o == '0));

    assert_no_overflow_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_o) & ~ovf_o) == '0);

    assert_tx_noreq_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_blocked |=> $stable(ovf_o));

    assert_high_word_spare_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_addr_i[ADDR_W-1]) |-> (reg_rdata_o[30:8] == '0));

    assert_capture_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_and_hiclr |=> $stable(ovf_o));
endmodule

bind ts_capture_bank ts_capture_bank_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .SLOT_W    (SLOT_W),
    .IDX_W     (IDX_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_valid_i (cap_valid_i),
    .cap_tx_i    (cap_tx_i),
    .cap_txreq_i (cap_txreq_i),
    .cap_port_i  (cap_port_i),
    .cap_slot_i  (cap_slot_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .ovf_o       (ovf_o)
);

// File: tb/ts_capture_bank_test.sv
module ts_capture_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;
    localparam int NS = 4;
    localparam int NT = NP * NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] timer_i = '0;
    logic        cap_valid_i = 1'b0, cap_tx_i = 1'b0, cap_txreq_i = 1'b0;
    logic [0:0]  cap_port_i = '0;
    logic [1:0]  cap_slot_i = '0;
    logic [3:0]  reg_addr_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [1:0]  ovf_o;

    int checks = 0;
    int fails  = 0;

    // scoreboard state
    logic [39:0] m_ts [NT];
    logic        m_v  [NT];
    logic [1:0]  m_ovf;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        pend_d = 1'b0, pend_q = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_capture_bank #(.NUM_PORTS(NP), .SLOTS(NS), .TMR_W(64)) uut (
        .clk(clk), .rst_n(rst_n), .timer_i(timer_i),
        .cap_valid_i(cap_valid_i), .cap_tx_i(cap_tx_i), .cap_txreq_i(cap_txreq_i),
        .cap_port_i(cap_port_i), .cap_slot_i(cap_slot_i),
        .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .ovf_o(ovf_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected register word per R5
    function automatic logic [31:0] exp_word(logic [3:0] a);
        logic [31:0] w = '0;
        int idx = int'(a[2:0]);
        if (a[3]) begin
            w[31]  = m_v[idx];
            w[7:0] = m_ts[idx][39:32];
        end else w = m_ts[idx][31:0];
        return w;
    endfunction

    // monitor: compares one read result per pending read
    always @(posedge clk) pend_q <= pend_d;
    always @(negedge clk) begin
        if (pend_q && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, reg_rdata_o, e);
        end
    end

    task automatic rd(logic [3:0] a, string tag);
        @(negedge clk);
        reg_addr_i = a;
        exp_q.push_back(exp_word(a));
        tag_q.push_back(tag);
        pend_d = 1'b1;
        @(negedge clk);
        pend_d = 1'b0;
    endtask

    task automatic rd_slot(int idx, string tag);
        rd({1'b0, 3'(idx)}, tag);
        rd({1'b1, 3'(idx)}, tag);
    endtask

    task automatic model_clr(int idx, logic hi);
        if (hi) begin m_ts[idx][39:32] = '0; m_v[idx] = 1'b0; end
        else m_ts[idx][31:0] = '0;
    endtask

    // event, optionally with a same-cycle zero write to the slot's high word
    task automatic cap(int port, int slot, logic tx, logic req, logic [63:0] t, logic hiclr);
        int idx = port * NS + slot;
        @(negedge clk);
        timer_i = t; cap_valid_i = 1'b1; cap_tx_i = tx; cap_txreq_i = req;
        cap_port_i = 1'(port); cap_slot_i = 2'(slot);
        if (hiclr) begin reg_wr_i = 1'b1; reg_wdata_i = '0; reg_addr_i = {1'b1, 3'(idx)}; end
        if (!tx || req) begin
            if (!m_v[idx] || hiclr) begin m_v[idx] = 1'b1; m_ts[idx] = t[39:0]; end
            else m_ovf[port] = 1'b1;
        end else if (hiclr) model_clr(idx, 1'b1);
        @(negedge clk);
        cap_valid_i = 1'b0; reg_wr_i = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        if (d == '0) model_clr(int'(a[2:0]), a[3]);
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R0 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NT; i++) begin m_ts[i] = '0; m_v[i] = 1'b0; end
        m_ovf = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ovf after reset", 32'(ovf_o), 32'(m_ovf));
        for (int i = 0; i < NT; i++) rd_slot(i, "R1 empty slot");

        // R2/R5: receive capture, split into low and high words
        cap(0, 1, 1'b0, 1'b0, 64'hABCD_1234_5678_9AB0, 1'b0);
        rd_slot(1, "R2 R5 rx capture p0s1");
        cap(1, 3, 1'b0, 1'b0, 64'h0000_00FF_DEAD_BEEF, 1'b0);
        rd_slot(7, "R2 rx capture p1s3");
        rd_slot(1, "R9 other slot kept");
        rd_slot(6, "R9 neighbour empty");

        // R3: capture into occupied slot
        cap(0, 1, 1'b0, 1'b0, 64'h1111_2222_3333_4444, 1'b0);
        check("R3 ovf port0 set", 32'(ovf_o), 32'(m_ovf));
        rd_slot(1, "R3 occupied slot kept");

        // R4: transmit without and with request
        cap(1, 0, 1'b1, 1'b0, 64'h0000_0099_0000_0001, 1'b0);
        rd_slot(4, "R4 tx without request ignored");
        check("R4 ovf unchanged", 32'(ovf_o), 32'(m_ovf));
        cap(1, 0, 1'b1, 1'b1, 64'h0000_0099_0000_0001, 1'b0);
        rd_slot(4, "R4 tx with request captured");

        // R7: nonzero writes ignored
        wr(4'b1_001, 32'h0000_0001);
        wr(4'b0_001, 32'hFFFF_FFFF);
        rd_slot(1, "R7 nonzero write ignored");

        // R6: zero writes clear each word
        wr(4'b0_001, 32'h0);
        rd_slot(1, "R6 low cleared");
        wr(4'b1_001, 32'h0);
        rd_slot(1, "R6 high and valid cleared");

        // R3: freed slot reusable, flag sticky
        cap(0, 1, 1'b0, 1'b0, 64'h0000_0042_0000_0007, 1'b0);
        rd_slot(1, "R3 reuse after clear");
        check("R3 ovf sticky", 32'(ovf_o), 32'(m_ovf));

        // R8: capture and high clear in the same cycle on an occupied slot
        cap(1, 3, 1'b0, 1'b0, 64'h0000_0077_1234_0000, 1'b1);
        rd_slot(7, "R8 capture wins over clear");
        check("R8 no overflow", 32'(ovf_o), 32'(m_ovf));

        // R10: one-cycle read latency
        @(negedge clk);
        reg_addr_i = 4'b0_111;
        @(negedge clk);
        reg_addr_i = 4'b0_001;
        #1;
        check("R10 old data before edge", reg_rdata_o, 32'h1234_0000);
        @(negedge clk);
        check("R10 new data after edge", reg_rdata_o, 32'h0000_0007);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule